// File: doc/BRIEF.md
# Seven-to-one parallel-to-serial link transmitter

The block takes a 28-bit parallel word on every rising edge of a word clock and sends it over four serial data lanes. A framing clock lane runs beside them. The bit clock comes from outside the block and runs at seven times the word clock. Each lane therefore carries seven bits per word period, so the serial lines toggle at up to 3.5 times the word rate.

The 28 input bits are not shifted out in order. Each bit has a fixed lane and a fixed time slot, and a receiver that uses the same scatter rebuilds the word. The framing lane is high for the first four slots of every word period and low for the last three, so its rising edge marks slot 0.

An active-low power-down input stops the link. While it is low, every output is low, the slot counter is held at 0 and the captured word is cleared. A 21-bit application ties inputs 21 to 27 to a constant level. The block still sends all seven slots on every lane.

Top module: `lvds7_serializer`

## Requirements
- R1: The word on `din` is captured on the rising edge of `word_clk`. The most recently captured word is loaded into the lanes at the next bit-clock edge where the slot counter is 0, and it is sent during the seven bit periods that follow.
- R2: The slot counter steps 0,1,...,6 on `bit_clk` and wraps from 6 to 0. Every lane emits exactly seven bits per word period, and slot 0 is sent first.
- R3: Lane 0 (`lane_o[0]`) sends input bits 7, 6, 4, 3, 2, 1, 0 in slots 0 to 6.
- R4: Lane 1 (`lane_o[1]`) sends input bits 18, 15, 14, 13, 12, 9, 8 in slots 0 to 6.
- R5: Lane 2 (`lane_o[2]`) sends input bits 26, 25, 24, 22, 21, 20, 19 in slots 0 to 6.
- R6: Lane 3 (`lane_o[3]`) sends input bits 23, 17, 16, 11, 10, 5, 27 in slots 0 to 6.
- R7: `clk_lane_o` is 1 in slots 0 to 3 and 0 in slots 4 to 6. Its rising edge coincides with slot 0 on the data lanes.
- R8: While `pd_n` is 0, every data lane and the clock lane are 0 at once, whatever `din` does. The slot counter and the captured word are cleared. After `pd_n` returns to 1, the first frame carries an all-zero word and normal serialization resumes.
- R9: With inputs 21 to 27 held constant (21-bit use), all seven slots of every lane are still sent, and the constant bits appear in their mapped slots.
- R10: Words captured on consecutive word-clock edges come out in consecutive frames, in order, with no gap and no frame lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the word clock |
| word_clk | input | 1 | Word clock; `din` is sampled on its rising edge |
| pd_n | input | 1 | Active-low power-down; low forces all outputs low |
| din | input | 28 | Parallel input word |
| lane_o | output | 4 | Serial data lanes, one bit per bit-clock period |
| clk_lane_o | output | 1 | Framing clock lane, 4 high / 3 low per word |

## Verification
A walking one across all 28 inputs gives each input bit a frame to itself, so every lane/slot assignment is pinned down separately and a swapped or shifted slot shows up as a lane mismatch. All-ones, all-zeros and the two alternating patterns separate stuck outputs and neighbouring-slot confusion. A pseudo-random stream sent back to back shows that frames are neither dropped nor repeated. The 21-bit patterns hold the top seven inputs at 1 and then at 0, which shows that those slots are still sent. A power-down in the middle of traffic, with `din` changing, has to give silent outputs and then a zero frame after release.

// File: rtl/lvds7_serializer.sv
module lvds7_serializer (
  input  logic        bit_clk,
  input  logic        word_clk,
  input  logic        pd_n,
  input  logic [27:0] din,
  output logic [3:0]  lane_o,
  output logic        clk_lane_o
);
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int WORD_W = LANES * SLOTS;
  localparam int CW = $clog2(SLOTS);
  localparam int HIGH_SLOTS = (SLOTS + 1) / 2;
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  localparam int MAP [LANES][SLOTS] = '{
    '{ 7,  6,  4,  3,  2,  1,  0},
    '{18, 15, 14, 13, 12,  9,  8},
    '{26, 25, 24, 22, 21, 20, 19},
    '{23, 17, 16, 11, 10,  5, 27}
  };

  logic [WORD_W-1:0] hold_q;
  logic [CW-1:0]     slot_q;
  logic              clk_q;

  always_ff @(posedge word_clk or negedge pd_n)
    if (!pd_n) hold_q <= '0;
    else       hold_q <= din;

  always_ff @(posedge bit_clk or negedge pd_n)
    if (!pd_n) begin
      slot_q <= '0;
      clk_q  <= 1'b0;
    end else begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      clk_q  <= (32'(slot_q) < HIGH_SLOTS);
    end

  assign clk_lane_o = clk_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] sh_q;
    always_ff @(posedge bit_clk or negedge pd_n)
      if (!pd_n) sh_q <= '0;
      else if (slot_q == '0)
        for (int s = 0; s < SLOTS; s++) sh_q[s] <= hold_q[MAP[l][s]];
      else sh_q <= {1'b0, sh_q[SLOTS-1:1]};
    assign lane_o[l] = sh_q[0];

    p_slot0_load_r1: assert property (@(posedge bit_clk) disable iff (!pd_n)
      slot_q == '0 |=> lane_o[l] == $past(hold_q[MAP[l][0]]));
  end

  p_slot_wrap_r2: assert property (@(posedge bit_clk) disable iff (!pd_n)
    slot_q == LAST |=> slot_q == '0);

  p_slot_range_r2: assert property (@(posedge bit_clk) disable iff (!pd_n)
    32'(slot_q) < SLOTS);

  p_clk_rise_r7: assert property (@(posedge bit_clk) disable iff (!pd_n)
    $rose(clk_lane_o) |-> slot_q == CW'(1));

  p_clk_fall_r7: assert property (@(posedge bit_clk) disable iff (!pd_n)
    $fell(clk_lane_o) |-> slot_q == CW'(HIGH_SLOTS + 1));

  p_pd_quiet_r8: assert property (@(posedge bit_clk)
    !pd_n |-> (lane_o == '0 && !clk_lane_o));
endmodule

// File: tb/lvds7_serializer_bench.sv
module lvds7_serializer_bench;
  logic        bit_clk = 1'b0;
  logic        word_clk = 1'b0;
  logic        pd_n = 1'b0;
  logic [27:0] din = '0;
  logic [3:0]  lane_o;
  logic        clk_lane_o;

  lvds7_serializer u_lvds7_serializer (
    .bit_clk(bit_clk), .word_clk(word_clk), .pd_n(pd_n), .din(din),
    .lane_o(lane_o), .clk_lane_o(clk_lane_o)
  );

  always #2 bit_clk = ~bit_clk;
  initial begin
    #4;
    forever begin word_clk = 1'b1; #14; word_clk = 1'b0; #14; end
  end

  typedef struct { logic [27:0] w; string tag; } item_t;
  item_t q[$];
  int checks = 0;
  int failures = 0;

  const int map [4][7] = '{
    '{ 7,  6,  4,  3,  2,  1,  0},
    '{18, 15, 14, 13, 12,  9,  8},
    '{26, 25, 24, 22, 21, 20, 19},
    '{23, 17, 16, 11, 10,  5, 27}
  };
  const string lane_tag [4] = '{"R3", "R4", "R5", "R6"};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [27:0] w, input string tag);
    @(negedge word_clk);
    din = w;
    q.push_back('{w, tag});
  endtask

  task automatic release_pd();
    @(posedge word_clk);
    #9;
    q.push_back('{28'h0, "R8"});
    pd_n = 1'b1;
  endtask

  // monitor: frames found by the rising edge of the clock lane
  logic [3:0] cap [7];
  logic [6:0] ckpat;
  int nbits = 0;
  int since = 0;
  bit seen = 0;
  logic prev_clk = 1'b0;

  always @(negedge bit_clk) begin
    if (!pd_n) begin
      nbits = 0; seen = 0; since = 0; prev_clk = 1'b0;
    end else begin
      if (nbits == 0) begin
        if (clk_lane_o && !prev_clk) begin
          if (seen) check(since == 7, "R2", since, 7);
          seen = 1; since = 0;
          cap[0] = lane_o; ckpat[0] = clk_lane_o; nbits = 1;
        end
      end else begin
        cap[nbits] = lane_o; ckpat[nbits] = clk_lane_o; nbits++;
        if (nbits == 7) begin
          nbits = 0;
          check(ckpat == 7'b0001111, "R7", ckpat, 7'b0001111);
          if (q.size() != 0) begin
            item_t e;
            logic [27:0] got;
            e = q.pop_front();
            got = '0;
            for (int l = 0; l < 4; l++) begin
              logic [6:0] la, le;
              for (int s = 0; s < 7; s++) begin
                la[s] = cap[s][l];
                le[s] = e.w[map[l][s]];
                got[map[l][s]] = cap[s][l];
              end
              check(la == le, lane_tag[l], la, le);
            end
            check(got == e.w, e.tag, got, e.w);
          end
        end
      end
      since++;
      prev_clk = clk_lane_o;
    end
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [27:0] lf;
    din = 28'hFFF_FFFF;
    repeat (5) @(negedge bit_clk);
    check(lane_o == 4'h0 && !clk_lane_o, "R8", {lane_o, clk_lane_o}, 0);

    release_pd();
    for (int i = 0; i < 28; i++) send(28'h1 << i, "R1");
    send(28'hFFF_FFFF, "R10");
    send(28'h000_0000, "R10");
    send(28'h555_5555, "R10");
    send(28'hAAA_AAAA, "R10");
    lf = 28'h9E3_7A51;
    for (int i = 0; i < 10; i++) begin
      lf = {lf[26:0], lf[27] ^ lf[24]};
      send(lf, "R10");
    end
    for (int i = 0; i < 6; i++) begin
      lf = {lf[26:0], lf[27] ^ lf[24]};
      send({7'h7F, lf[20:0]}, "R9");
    end
    for (int i = 0; i < 6; i++) begin
      lf = {lf[26:0], lf[27] ^ lf[24]};
      send({7'h00, lf[20:0]}, "R9");
    end
    repeat (4) @(posedge word_clk);
    check(q.size() == 0, "R10", q.size(), 0);

    @(negedge bit_clk); #1;
    pd_n = 1'b0;
    #0.5;
    check(lane_o == 4'h0 && !clk_lane_o, "R8", {lane_o, clk_lane_o}, 0);
    for (int i = 0; i < 6; i++) begin
      din = 28'h1234567 ^ (28'h0F0F0F0 << i);
      repeat (5) @(negedge bit_clk);
      check(lane_o == 4'h0 && !clk_lane_o, "R8", {lane_o, clk_lane_o}, 0);
    end
    din = 28'hBEEF123;

    release_pd();
    send(28'h0C3A5F1, "R8");
    send(28'h7FFFFFF, "R8");
    send(28'h8000001, "R10");
    repeat (4) @(posedge word_clk);
    check(q.size() == 0, "R10", q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule